// File: doc/BRIEF.md
# Round-Robin Hardware Thread Scheduler

This block shares one execution core among a fixed set of hardware thread contexts. It keeps a stored copy of each context: a program counter, a bank of general registers with one of them used as the stack pointer, and six condition flags. It also keeps a slice countdown that the core's retire strobe steps down. A switch happens when the countdown runs out, when the core retires a yield, or when the running thread retires a halt. On a switch the block picks the next thread that has not halted, in round-robin order. It then hands that thread's stored context back to the core with a one-cycle restore pulse and moves its current-thread index.

Software starts a run with a start pulse. The pulse latches the slice length, the slice mode (fixed, or a pseudo-random length from a seeded LFSR) and the seed. It also puts every context back to its boot image. The run ends once every thread has halted, and the block then holds the number of instructions retired during the run. Decoding and executing instructions happen elsewhere. The core presents its live context together with each retire strobe, and it loads whatever the block restores.

Top module: `rr_thread_sched`

## Requirements
- R1: A start pulse clears all halt marks and the retire total, and makes thread 0 current. It sets every stored context to its boot image: PC = LOAD_ADDR, register SP_IDX = SP_TOP - t*SP_STEP for thread t, and all other registers and flags zero. In the next cycle the block raises the restore pulse carrying thread 0's boot image and sets the running flag. The context word holds the flags in bits [5:0], register k in bits [6+k*DATA_W +: DATA_W], and the PC in the top ADDR_W bits.
- R2: After reset the block is idle. The current index, restore pulse, running, done flag, retire total and slice count are all zero.
- R3: Each retire while running lowers the slice count by one. A retire that brings the count to zero saves the live context into the current thread's slot and switches to the next runnable thread. It also reloads the count.
- R4: A retired yield that is not a halt switches in the same way as an expiry. It saves the live context, switches and reloads the count.
- R5: A retired halt marks the current thread done and switches to the next thread not done. The halted thread's context is not saved. The count is only decremented, not reloaded, unless it reaches zero.
- R6: If a halt's decrement brings the count to zero, a second switch follows in the same step. The block lands on the runnable thread after the one the halt selected, and it reloads the count.
- R7: The search scans indices current+1 up to N-1, then 0 up to and including current. When only the current thread is runnable, an expiry or yield switches to that thread and restores the context that was just saved.
- R8: When a halt leaves no runnable thread, running drops and the done flag rises. The retire total then holds the number of retires in the run, and further retires change nothing.
- R9: In random mode each reload value is ((lfsr * interval) >> 16) + 1, with lfsr the current 16-bit state. After every reload, and after the start load, the state steps as a right-shifting Galois LFSR: next = (s >> 1) ^ (s[0] ? 16'hB400 : 0). The seed loads at start, and a zero seed becomes 1. In fixed mode the reload value is the interval.
- R10: An interval of zero is treated as 1, so every retire switches.
- R11: A retire with both halt and yield set behaves as a plain halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a run; latches configuration and boots contexts |
| cfg_interval_i | input | IVL_W | Slice length (0 treated as 1) |
| cfg_random_i | input | 1 | 1 selects pseudo-random slice lengths |
| cfg_seed_i | input | 16 | LFSR seed |
| ret_valid_i | input | 1 | One instruction retired this cycle |
| ret_halt_i | input | 1 | The retired instruction is a halt |
| ret_yield_i | input | 1 | The retired instruction is a yield |
| live_ctx_i | input | CTX_W | Core's current context, saved on switches |
| cur_thread_o | output | TW | Index of the thread owning the core |
| restore_o | output | 1 | Pulse: core must load restore_ctx_o |
| restore_ctx_o | output | CTX_W | Context to load |
| running_o | output | 1 | A run is in progress |
| all_done_o | output | 1 | Every thread has halted |
| retired_total_o | output | CNT_W | Retires counted in this run |
| slice_left_o | output | IVL_W | Remaining slice count |

## Verification
The assertions assume that a retire strobe is meaningful only while a run is active. They also assume that start takes precedence over a retire arriving in the same cycle. The bench therefore never raises start during a retire and always leaves at least one cycle between runs. The random stimulus keeps intervals small, from 0 to 9, so that expiries, yields and halts overlap often, including halts that land on an expiry. Directed sequences then cover the single-survivor self switch and retires that arrive after the run has finished.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    localparam int FLAG_W = 6;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

    typedef enum logic [2:0] {
        SW_NONE,
        SW_SAVE,
        SW_DROP,
        SW_DROP2,
        SW_FINISH
    } sw_kind_e;

    function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
        return {1'b0, s[LFSR_W-1:1]} ^ (s[0] ? LFSR_TAPS : '0);
    endfunction

endpackage

// File: rtl/sched_pick.sv
module sched_pick #(
    parameter int N  = 4,
    parameter int TW = 2
) (
    input  logic [TW-1:0] from_idx,
    input  logic [N-1:0]  done,
    output logic [TW-1:0] next_idx,
    output logic          found
);
    always_comb begin
        next_idx = from_idx;
        found    = 1'b0;
        for (int k = N; k >= 1; k--) begin
            int cand;
            cand = int'(from_idx) + k;
            if (cand >= N) cand = cand - N;
            if (!done[cand]) begin
                next_idx = TW'(cand);
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sched_slice.sv
module sched_slice import rrs_pkg::*; #(
    parameter int IW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [IW-1:0]     cfg_ivl_i,
    input  logic              cfg_rnd_i,
    input  logic [LFSR_W-1:0] cfg_seed_i,
    input  logic              step_i,
    input  logic              force_i,
    output logic [IW-1:0]     left_o,
    output logic              expire_o
);
    localparam int PW = LFSR_W + IW;

    logic [IW-1:0]     ivl_q, left_q;
    logic              rnd_q;
    logic [LFSR_W-1:0] lfsr_q;
    logic [IW-1:0]     cfg_ivl_eff;
    logic [LFSR_W-1:0] seed_eff;
    logic              reload_now;

    function automatic logic [IW-1:0] slice_len(input logic rnd,
                                                input logic [LFSR_W-1:0] s,
                                                input logic [IW-1:0] ivl);
        logic [PW-1:0] prod;
        prod = PW'(s) * PW'(ivl);
        return rnd ? (prod[LFSR_W +: IW] + IW'(1)) : ivl;
    endfunction

    assign cfg_ivl_eff = (cfg_ivl_i == '0) ? IW'(1) : cfg_ivl_i;
    assign seed_eff    = (cfg_seed_i == '0) ? LFSR_W'(1) : cfg_seed_i;
    assign expire_o    = step_i && (left_q == IW'(1));
    assign reload_now  = step_i && (expire_o || force_i);
    assign left_o      = left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q  <= '0;
            rnd_q  <= 1'b0;
            lfsr_q <= LFSR_W'(1);
            left_q <= '0;
        end else if (start_i) begin
            ivl_q  <= cfg_ivl_eff;
            rnd_q  <= cfg_rnd_i;
            left_q <= slice_len(cfg_rnd_i, seed_eff, cfg_ivl_eff);
            lfsr_q <= lfsr_advance(seed_eff);
        end else if (reload_now) begin
            left_q <= slice_len(rnd_q, lfsr_q, ivl_q);
            lfsr_q <= lfsr_advance(lfsr_q);
        end else if (step_i) begin
            left_q <= left_q - IW'(1);
        end
    end
endmodule

// File: rtl/sched_ctx_bank.sv
module sched_ctx_bank import rrs_pkg::*; #(
    parameter int N         = 4,
    parameter int TW        = 2,
    parameter int NREG      = 5,
    parameter int SP_IDX    = 4,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] LOAD_ADDR = '0,
    parameter int SP_TOP    = 4096,
    parameter int SP_STEP   = 256,
    parameter int CTX_W     = FLAG_W + NREG*DATA_W + ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_i,
    input  logic             we_i,
    input  logic [TW-1:0]    wr_idx_i,
    input  logic [CTX_W-1:0] wr_ctx_i,
    input  logic [TW-1:0]    rd_idx_i,
    output logic [CTX_W-1:0] rd_ctx_o
);
    function automatic logic [CTX_W-1:0] boot_ctx(input int t);
        logic [CTX_W-1:0] c;
        c = '0;
        c[CTX_W-1 -: ADDR_W] = LOAD_ADDR;
        c[FLAG_W + SP_IDX*DATA_W +: DATA_W] = DATA_W'(SP_TOP - t*SP_STEP);
        return c;
    endfunction

    logic [CTX_W-1:0] slot_q [N];

    for (genvar t = 0; t < N; t++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || init_i) begin
                slot_q[t] <= boot_ctx(t);
            end else if (we_i && (wr_idx_i == TW'(t))) begin
                slot_q[t] <= wr_ctx_i;
            end
        end
    end

    assign rd_ctx_o = init_i ? boot_ctx(int'(rd_idx_i)) : slot_q[rd_idx_i];
endmodule

// File: rtl/rr_thread_sched.sv
module rr_thread_sched import rrs_pkg::*; #(
    parameter int N_THREADS = 4,
    parameter int NREG      = 5,
    parameter int SP_IDX    = 4,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 16,
    parameter int IVL_W     = 8,
    parameter int CNT_W     = 32,
    parameter logic [ADDR_W-1:0] LOAD_ADDR = 16'd1000,
    parameter int SP_TOP    = 4096,
    parameter int SP_STEP   = 256,
    localparam int TW       = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
    localparam int CTX_W    = FLAG_W + NREG*DATA_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [IVL_W-1:0]  cfg_interval_i,
    input  logic              cfg_random_i,
    input  logic [15:0]       cfg_seed_i,
    input  logic              ret_valid_i,
    input  logic              ret_halt_i,
    input  logic              ret_yield_i,
    input  logic [CTX_W-1:0]  live_ctx_i,
    output logic [TW-1:0]     cur_thread_o,
    output logic              restore_o,
    output logic [CTX_W-1:0]  restore_ctx_o,
    output logic              running_o,
    output logic              all_done_o,
    output logic [CNT_W-1:0]  retired_total_o,
    output logic [IVL_W-1:0]  slice_left_o
);
    logic [TW-1:0]        cur_q;
    logic [N_THREADS-1:0] done_q, done_nx;
    logic                 running_q, all_done_q, restore_q;
    logic [CTX_W-1:0]     restore_ctx_q;
    logic [CNT_W-1:0]     total_q;

    logic                 step, halt_ev, yield_ev, expire;
    logic [TW-1:0]        a_idx, b_idx, target, rd_idx;
    logic                 a_found, b_found;
    logic [CTX_W-1:0]     bank_rd, restore_data;
    sw_kind_e             kind;

    assign step     = ret_valid_i && running_q && !start_i;
    assign halt_ev  = step && ret_halt_i;
    assign yield_ev = step && ret_yield_i && !ret_halt_i;
    assign done_nx  = done_q | (halt_ev ? (N_THREADS'(1) << cur_q) : '0);

    sched_slice #(.IW(IVL_W)) u_slice (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cfg_ivl_i (cfg_interval_i),
        .cfg_rnd_i (cfg_random_i),
        .cfg_seed_i(cfg_seed_i),
        .step_i    (step),
        .force_i   (yield_ev),
        .left_o    (slice_left_o),
        .expire_o  (expire)
    );

    sched_pick #(.N(N_THREADS), .TW(TW)) u_pick_a (
        .from_idx(cur_q),
        .done    (done_nx),
        .next_idx(a_idx),
        .found   (a_found)
    );

    sched_pick #(.N(N_THREADS), .TW(TW)) u_pick_b (
        .from_idx(a_idx),
        .done    (done_nx),
        .next_idx(b_idx),
        .found   (b_found)
    );

    always_comb begin
        kind = SW_NONE;
        if (halt_ev) begin
            if (!a_found)               kind = SW_FINISH;
            else if (expire && b_found) kind = SW_DROP2;
            else                        kind = SW_DROP;
        end else if (yield_ev || expire) begin
            kind = SW_SAVE;
        end
    end

    assign target = (kind == SW_DROP2) ? b_idx : a_idx;
    assign rd_idx = start_i ? '0 : target;

    sched_ctx_bank #(
        .N(N_THREADS), .TW(TW), .NREG(NREG), .SP_IDX(SP_IDX),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOAD_ADDR(LOAD_ADDR),
        .SP_TOP(SP_TOP), .SP_STEP(SP_STEP), .CTX_W(CTX_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .init_i  (start_i),
        .we_i    (kind == SW_SAVE),
        .wr_idx_i(cur_q),
        .wr_ctx_i(live_ctx_i),
        .rd_idx_i(rd_idx),
        .rd_ctx_o(bank_rd)
    );

    assign restore_data = ((kind == SW_SAVE) && (target == cur_q)) ? live_ctx_i : bank_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q         <= '0;
            done_q        <= '0;
            running_q     <= 1'b0;
            all_done_q    <= 1'b0;
            restore_q     <= 1'b0;
            restore_ctx_q <= '0;
            total_q       <= '0;
        end else if (start_i) begin
            cur_q         <= '0;
            done_q        <= '0;
            running_q     <= 1'b1;
            all_done_q    <= 1'b0;
            restore_q     <= 1'b1;
            restore_ctx_q <= bank_rd;
            total_q       <= '0;
        end else begin
            restore_q <= 1'b0;
            if (step) begin
                total_q <= total_q + CNT_W'(1);
                done_q  <= done_nx;
            end
            unique case (kind)
                SW_SAVE, SW_DROP, SW_DROP2: begin
                    cur_q         <= target;
                    restore_q     <= 1'b1;
                    restore_ctx_q <= restore_data;
                end
                SW_FINISH: begin
                    running_q  <= 1'b0;
                    all_done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cur_thread_o    = cur_q;
    assign restore_o       = restore_q;
    assign restore_ctx_o   = restore_ctx_q;
    assign running_o       = running_q;
    assign all_done_o      = all_done_q;
    assign retired_total_o = total_q;
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
    parameter int N  = 4,
    parameter int TW = 2,
    parameter int IW = 8,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          ret_valid_i,
    input logic          ret_halt_i,
    input logic          ret_yield_i,
    input logic [TW-1:0] cur_thread_o,
    input logic          restore_o,
    input logic          running_o,
    input logic          all_done_o,
    input logic [CW-1:0] total_o,
    input logic [IW-1:0] slice_left_o,
    input logic [N-1:0]  done_q
);
    // R5
    cur_runnable_chk: assert property (@(posedge clk) disable iff (rst)
        running_o |-> !done_q[cur_thread_o]);

    // R3
    slice_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        running_o |-> (slice_left_o != '0));

    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (($past(done_q) & ~done_q) == '0));

    // R8
    finish_idle_chk: assert property (@(posedge clk) disable iff (rst)
        all_done_o |-> !running_o);

    // R8
    total_step_chk: assert property (@(posedge clk) disable iff (rst)
        (running_o && ret_valid_i && !start_i) |=> (total_o == $past(total_o) + CW'(1)));

    // R4
    yield_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (running_o && ret_valid_i && ret_yield_i && !ret_halt_i && !start_i) |=> restore_o);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!running_o && !start_i) |=> (!restore_o && $stable(total_o)));
endmodule

bind rr_thread_sched sched_chk #(
    .N(N_THREADS), .TW(TW), .IW(IVL_W), .CW(CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .ret_valid_i (ret_valid_i),
    .ret_halt_i  (ret_halt_i),
    .ret_yield_i (ret_yield_i),
    .cur_thread_o(cur_thread_o),
    .restore_o   (restore_o),
    .running_o   (running_o),
    .all_done_o  (all_done_o),
    .total_o     (retired_total_o),
    .slice_left_o(slice_left_o),
    .done_q      (done_q)
);

// File: tb/rr_thread_sched_tb.sv
module rr_thread_sched_tb;
    localparam int N      = 4;
    localparam int NREG   = 5;
    localparam int SPI    = 4;
    localparam int W      = 16;
    localparam int AW     = 16;
    localparam int IW     = 8;
    localparam int CW     = 32;
    localparam int LOAD   = 1000;
    localparam int SPTOP  = 4096;
    localparam int SPSTEP = 256;
    localparam int TW     = 2;
    localparam int CTX_W  = 6 + NREG*W + AW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [IW-1:0]    cfg_interval_i = '0;
    logic             cfg_random_i = 1'b0;
    logic [15:0]      cfg_seed_i = '0;
    logic             ret_valid_i = 1'b0;
    logic             ret_halt_i = 1'b0;
    logic             ret_yield_i = 1'b0;
    logic [CTX_W-1:0] live_ctx_i = '0;
    logic [TW-1:0]    cur_thread_o;
    logic             restore_o;
    logic [CTX_W-1:0] restore_ctx_o;
    logic             running_o;
    logic             all_done_o;
    logic [CW-1:0]    retired_total_o;
    logic [IW-1:0]    slice_left_o;

    always #2 clk = ~clk;

    rr_thread_sched #(
        .N_THREADS(N), .NREG(NREG), .SP_IDX(SPI), .DATA_W(W), .ADDR_W(AW),
        .IVL_W(IW), .CNT_W(CW), .LOAD_ADDR(16'(LOAD)), .SP_TOP(SPTOP), .SP_STEP(SPSTEP)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .cfg_interval_i(cfg_interval_i),
        .cfg_random_i(cfg_random_i), .cfg_seed_i(cfg_seed_i), .ret_valid_i(ret_valid_i),
        .ret_halt_i(ret_halt_i), .ret_yield_i(ret_yield_i), .live_ctx_i(live_ctx_i),
        .cur_thread_o(cur_thread_o), .restore_o(restore_o), .restore_ctx_o(restore_ctx_o),
        .running_o(running_o), .all_done_o(all_done_o), .retired_total_o(retired_total_o),
        .slice_left_o(slice_left_o)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // reference model state
    logic [CTX_W-1:0] m_bank [N];
    logic [N-1:0]     m_done;
    int               m_cur, m_cnt, m_ivl, m_total;
    bit               m_rnd, m_run, m_alldone, m_restore;
    logic [15:0]      m_lfsr;
    logic [CTX_W-1:0] m_ctx;

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [CTX_W-1:0] boot(input int t);
        logic [CTX_W-1:0] c;
        c = '0;
        c[CTX_W-1 -: AW] = AW'(LOAD);
        c[6 + SPI*W +: W] = W'(SPTOP - t*SPSTEP);
        return c;
    endfunction

    function automatic int mpick(input int from, input logic [N-1:0] d, output bit found);
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (from + k) % N;
            if (!d[c]) begin
                found = 1'b1;
                return c;
            end
        end
        return from;
    endfunction

    task automatic m_reload();
        if (m_rnd) m_cnt = int'((longint'(m_lfsr) * longint'(m_ivl)) >>> 16) + 1;
        else       m_cnt = m_ivl;
        m_lfsr = {1'b0, m_lfsr[15:1]} ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
    endtask

    function automatic logic [CTX_W-1:0] rand_ctx();
        logic [127:0] r;
        r = {$urandom, $urandom, $urandom, $urandom};
        return r[CTX_W-1:0];
    endfunction

    task automatic check_all(input string req);
        chk(req, "cur_thread", 128'(cur_thread_o), 128'(m_cur));
        chk(req, "restore", 128'(restore_o), 128'(m_restore));
        if (m_restore) chk(req, "restore_ctx", 128'(restore_ctx_o), 128'(m_ctx));
        chk(req, "running", 128'(running_o), 128'(m_run));
        chk(req, "all_done", 128'(all_done_o), 128'(m_alldone));
        chk(req, "total", 128'(retired_total_o), 128'(m_total));
        chk(req, "slice_left", 128'(slice_left_o), 128'(m_cnt));
    endtask

    task automatic do_start(input int ivl, input bit rnd, input logic [15:0] seed);
        cfg_interval_i = IW'(ivl);
        cfg_random_i   = rnd;
        cfg_seed_i     = seed;
        start_i        = 1'b1;
        m_ivl = (ivl == 0) ? 1 : ivl;
        m_rnd = rnd;
        m_lfsr = (seed == 16'h0) ? 16'h0001 : seed;
        m_reload();
        for (int t = 0; t < N; t++) m_bank[t] = boot(t);
        m_done = '0; m_cur = 0; m_run = 1'b1; m_alldone = 1'b0; m_total = 0;
        m_restore = 1'b1; m_ctx = boot(0);
        @(negedge clk);
        start_i = 1'b0;
        check_all("R1");
    endtask

    task automatic do_idle(input string req);
        ret_valid_i = 1'b0;
        m_restore = 1'b0;
        @(negedge clk);
        check_all(req);
    endtask

    task automatic do_retire(input bit h, input bit y, input logic [CTX_W-1:0] live, input string req);
        bit yl, ex, fa, fb;
        int a, tgt;
        ret_valid_i = 1'b1; ret_halt_i = h; ret_yield_i = y; live_ctx_i = live;
        m_restore = 1'b0;
        if (m_run) begin
            m_total++;
            yl = y && !h;
            m_cnt--;
            ex = (m_cnt == 0);
            if (ex || yl) m_reload();
            if (h) begin
                m_done[m_cur] = 1'b1;
                a = mpick(m_cur, m_done, fa);
                if (!fa) begin
                    m_run = 1'b0; m_alldone = 1'b1;
                end else begin
                    tgt = ex ? mpick(a, m_done, fb) : a;
                    m_cur = tgt; m_restore = 1'b1; m_ctx = m_bank[tgt];
                end
            end else if (ex || yl) begin
                m_bank[m_cur] = live;
                tgt = mpick(m_cur, m_done, fa);
                m_cur = tgt; m_restore = 1'b1; m_ctx = m_bank[tgt];
            end
        end
        @(negedge clk);
        ret_valid_i = 1'b0; ret_halt_i = 1'b0; ret_yield_i = 1'b0;
        check_all(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [CTX_W-1:0] keep;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R2: reset state
        m_cur = 0; m_restore = 0; m_run = 0; m_alldone = 0; m_total = 0; m_cnt = 0;
        check_all("R2");
        rst = 1'b0;
        do_idle("R2");

        // R3 fixed slices, R4 yield
        do_start(3, 1'b0, 16'h0);
        do_retire(0, 0, rand_ctx(), "R3");
        do_retire(0, 0, rand_ctx(), "R3");
        do_retire(0, 0, rand_ctx(), "R3");
        chk("R3", "switched to thread 1", 128'(cur_thread_o), 128'(1));
        do_retire(0, 1, rand_ctx(), "R4");
        chk("R4", "yield moves to thread 2", 128'(cur_thread_o), 128'(2));
        chk("R4", "slice reloaded", 128'(slice_left_o), 128'(3));
        for (int i = 0; i < 6; i++) do_retire(0, 0, rand_ctx(), "R3");
        do_idle("R3");

        // R10 zero interval
        do_start(0, 1'b0, 16'h0);
        for (int i = 0; i < 5; i++) do_retire(0, 0, rand_ctx(), "R10");
        chk("R10", "switch each retire", 128'(cur_thread_o), 128'(1));

        // R5 halt without expiry, R6 halt on expiry
        do_start(5, 1'b0, 16'h0);
        do_retire(1, 0, rand_ctx(), "R5");
        chk("R5", "halt moves to thread 1, count 4", 128'({cur_thread_o, slice_left_o}), 128'({2'd1, 8'd4}));
        do_start(2, 1'b0, 16'h0);
        do_retire(0, 0, rand_ctx(), "R6");
        do_retire(1, 0, rand_ctx(), "R6");
        chk("R6", "double switch lands on 2", 128'(cur_thread_o), 128'(2));
        chk("R6", "boot ctx of 2", 128'(restore_ctx_o), 128'(boot(2)));

        // R7 single survivor, R11 halt+yield
        do_start(50, 1'b0, 16'h0);
        do_retire(1, 1, rand_ctx(), "R11");
        chk("R11", "halt+yield is halt, count 49", 128'(slice_left_o), 128'(49));
        do_retire(1, 0, rand_ctx(), "R7");
        do_retire(1, 0, rand_ctx(), "R7");
        keep = rand_ctx();
        do_retire(0, 1, keep, "R7");
        chk("R7", "self switch thread", 128'(cur_thread_o), 128'(3));
        chk("R7", "self switch ctx", 128'(restore_ctx_o), 128'(keep));
        // R8 finish and ignored retires
        do_retire(1, 0, rand_ctx(), "R8");
        chk("R8", "all done", 128'(all_done_o), 128'(1));
        for (int i = 0; i < 3; i++) do_retire(i == 0, i == 1, rand_ctx(), "R8");
        chk("R8", "total held at 5", 128'(retired_total_o), 128'(5));
        do_idle("R8");

        // R9 random mode directed
        do_start(7, 1'b1, 16'hACE1);
        for (int i = 0; i < 20; i++) do_retire(0, 0, rand_ctx(), "R9");
        do_idle("R9");
        do_start(5, 1'b1, 16'h0);
        for (int i = 0; i < 10; i++) do_retire(0, 0, rand_ctx(), "R9");
        do_idle("R9");

        // constrained random runs
        for (int run = 0; run < 8; run++) begin
            do_start(int'($urandom_range(0, 9)), 1'($urandom_range(0, 1)), 16'($urandom));
            for (int op = 0; op < 400 && m_run; op++) begin
                int r;
                r = int'($urandom_range(0, 99));
                if (r < 20)      do_idle("R3");
                else if (r < 24) do_retire(1, 1'($urandom_range(0, 1)), rand_ctx(), "R5");
                else if (r < 34) do_retire(0, 1, rand_ctx(), "R4");
                else             do_retire(0, 0, rand_ctx(), "R9");
            end
            while (m_run) do_retire(1, 0, rand_ctx(), "R8");
            do_retire(0, 0, rand_ctx(), "R8");
            do_idle("R8");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule